// File: doc/BRIEF.md
# Two-Phase Accumulator Processor Core

This core is a small 16-bit accumulator machine. Every instruction is one 16-bit word: the upper four bits give the operation and the lower twelve bits give a direct word address. Programmer-visible state is an accumulator, a program counter that spans 64K words, a scratch register used only by the store-through-accumulator instruction, and carry and zero flags. Instructions and data share a single synchronous memory port. Read data appears one clock after the address is driven.

Each instruction takes exactly two clock cycles on the memory port. The first cycle is the data cycle: it reads the direct operand, reads through the accumulator, or writes the scratch register through the accumulator. The second cycle is the fetch cycle: it reads the next instruction. Every jump and branch takes its target from a memory word. The data read in the fetch cycle therefore steers the fetch address in that same cycle, with no extra cycle spent on a taken branch. Debug outputs expose the accumulator, the program counter and both flags.

Top module: `acc_core`

## Requirements
- R1: Instruction words are decoded as opcode = bits [15:12] and direct address = bits [11:0], zero-extended to 16 bits. The opcode values are: 0 JMP, 1 BCC, 2 BNE, 3 LDC, 4 LDA, 5 STA, 6 XOR, 7 OR, 8 AND, 9 ADC, 10 SBC, 11 ROR, 12 TAT, 13 LDI, 14 STT, 15 HALT.
- R2: After reset is released, one cycle fetches address 0. After that, every instruction uses exactly one data cycle and one fetch cycle. The PC changes only at the end of the fetch cycle, so it equals k after 1+2k clock edges for straight-line code. The write enable is never high on two consecutive cycles.
- R3: JMP sets PC to the word stored at its direct address.
- R4: BCC sets PC to the word at its direct address when C is 0. Otherwise PC advances by one.
- R5: BNE sets PC to the word at its direct address when Z is 0. Otherwise PC advances by one.
- R6: LDA loads A from the direct address and leaves C unchanged. LDC does the same and also clears C. LDI loads A from the address held in A.
- R7: STA writes A to the direct address. TAT copies A into T and leaves A unchanged. STT writes T to the address held in A.
- R8: XOR, OR and AND combine A with the direct operand bitwise and place the result in A.
- R9: ADC sets A to A plus the operand, modulo 2^16, with no carry-in. C becomes the carry-out.
- R10: SBC sets A to A minus the operand minus C, modulo 2^16. C becomes 1 exactly when that difference is negative (borrow-out).
- R11: ROR rotates the 17-bit value {A, C} right by one: the new A is {C, A[15:1]} and the new C is A[0].
- R12: C changes only on LDC, ADC, SBC and ROR. Z equals 1 exactly when A is zero after every instruction.
- R13: Opcode 15 stops the core. After the halt, PC stays at the halt word's address, A is frozen and no write occurs.
- R14: While reset is held, A = 0, PC = 0, C = 0, Z = 1 and write enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Shared memory word address |
| mem_rdata | input | 16 | Read data, valid one cycle after its address |
| mem_wdata | output | 16 | Write data |
| mem_we | output | 1 | Write enable for the current address |
| dbg_a | output | 16 | Accumulator |
| dbg_pc | output | 16 | Program counter |
| dbg_c | output | 1 | Carry flag |
| dbg_z | output | 1 | Zero flag |

## Verification
The following properties are checked on every cycle:
- writes are isolated to single cycles;
- the PC moves only at the close of a fetch cycle;
- carry is held by every operation that must not touch it;
- Z mirrors A;
- a not-taken BCC steps the PC by one;
- an STA puts A on the write bus;
- a halted core stays frozen.

The arithmetic results, the flag values after borrow and rotation, the indirect branch targets, and the round trip of T through memory and back via LDI can only be shown by running the bench programs and comparing against values worked out by hand.

// File: rtl/acc_cpu_pkg.sv
// Package: shared types for the accumulator core.
// Holds the instruction field widths, the opcode encoding and the phase
// encoding of the two-cycle instruction loop.
package acc_cpu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_JMP  = 4'd0,
        OP_BCC  = 4'd1,
        OP_BNE  = 4'd2,
        OP_LDC  = 4'd3,
        OP_LDA  = 4'd4,
        OP_STA  = 4'd5,
        OP_XOR  = 4'd6,
        OP_OR   = 4'd7,
        OP_AND  = 4'd8,
        OP_ADC  = 4'd9,
        OP_SBC  = 4'd10,
        OP_ROR  = 4'd11,
        OP_TAT  = 4'd12,
        OP_LDI  = 4'd13,
        OP_STT  = 4'd14,
        OP_HALT = 4'd15
    } opcode_t;

    typedef enum logic [1:0] {
        PH_BOOT  = 2'd0,
        PH_DATA  = 2'd1,
        PH_FETCH = 2'd2,
        PH_HALT  = 2'd3
    } phase_t;

    // True for the operations allowed to write the carry flag.
    function automatic logic writes_carry(opcode_t op);
        return (op == OP_LDC) || (op == OP_ADC) || (op == OP_SBC) || (op == OP_ROR);
    endfunction

endpackage

// File: rtl/acc_alu.sv
// Module: acc_alu
// Combinational datapath for the accumulator and carry.
// Assumes: operand is the word read in the data cycle. Operations that do
// not touch A or C pass them through unchanged.
module acc_alu
    import acc_cpu_pkg::*;
#(
    parameter int W = 16
) (
    input  opcode_t        op,
    input  logic [W-1:0]   acc,
    input  logic [W-1:0]   operand,
    input  logic           carry,
    output logic [W-1:0]   acc_next,
    output logic           carry_next
);

    logic [W:0] sum_w;
    logic [W:0] diff_w;

    // Wide add and subtract, so the top bit is the carry or borrow.
    always_comb begin
        sum_w  = {1'b0, acc} + {1'b0, operand};
        diff_w = {1'b0, acc} - {1'b0, operand} - {{W{1'b0}}, carry};
    end

    // Select the result for each operation.
    always_comb begin
        acc_next   = acc;
        carry_next = carry;
        unique case (op)
            OP_LDC: begin acc_next = operand; carry_next = 1'b0; end
            OP_LDA,
            OP_LDI: acc_next = operand;
            OP_XOR: acc_next = acc ^ operand;
            OP_OR:  acc_next = acc | operand;
            OP_AND: acc_next = acc & operand;
            OP_ADC: begin acc_next = sum_w[W-1:0];  carry_next = sum_w[W];  end
            OP_SBC: begin acc_next = diff_w[W-1:0]; carry_next = diff_w[W]; end
            OP_ROR: begin acc_next = {carry, acc[W-1:1]}; carry_next = acc[0]; end
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_pcunit.sv
// Module: acc_pcunit
// Next-PC selection. Every control transfer is indirect through the word
// just read. Assumes: zero reflects the accumulator before the branch.
module acc_pcunit
    import acc_cpu_pkg::*;
#(
    parameter int W = 16
) (
    input  opcode_t        op,
    input  logic [W-1:0]   pc,
    input  logic [W-1:0]   vector_word,
    input  logic           carry,
    input  logic           zero,
    output logic [W-1:0]   pc_next
);

    logic taken;

    // Decide whether this instruction transfers control.
    always_comb begin
        unique case (op)
            OP_JMP:  taken = 1'b1;
            OP_BCC:  taken = !carry;
            OP_BNE:  taken = !zero;
            default: taken = 1'b0;
        endcase
    end

    // Take the vector word or step to the next instruction.
    always_comb pc_next = taken ? vector_word : pc + W'(1);

endmodule

// File: rtl/acc_phase.sv
// Module: acc_phase
// Cycle sequencer: one boot fetch, then data and fetch cycles alternating.
// Moves to a halt phase when a halt opcode is seen.
// Assumes: fetched_op is valid during the data phase.
module acc_phase
    import acc_cpu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  opcode_t fetched_op,
    output phase_t  phase_q
);

    // Advance the phase each cycle; reset starts with the boot fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_BOOT;
        end else begin
            unique case (phase_q)
                PH_BOOT:  phase_q <= PH_DATA;
                PH_DATA:  phase_q <= (fetched_op == OP_HALT) ? PH_HALT : PH_FETCH;
                PH_FETCH: phase_q <= PH_DATA;
                default:  phase_q <= PH_HALT;
            endcase
        end
    end

endmodule

// File: rtl/acc_core.sv
// Module: acc_core (top)
// 16-bit accumulator processor on one synchronous memory port.
// Data cycle: the instruction word is on mem_rdata; the core drives the
// operand address and, for stores, the write.
// Fetch cycle: the operand is on mem_rdata; the core updates its state and
// drives the next instruction address from that operand.
// Assumes: memory returns read data one clock after the address.
module acc_core
    import acc_cpu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [WORD_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [WORD_W-1:0] dbg_a,
    output logic [WORD_W-1:0] dbg_pc,
    output logic              dbg_c,
    output logic              dbg_z
);

    localparam int ADDR_W = WORD_W - OP_W;

    logic [WORD_W-1:0] a_q, t_q, pc_q;
    logic              c_q, z_q;
    opcode_t           op_q;
    phase_t            phase_q;

    opcode_t           rd_op;
    logic [WORD_W-1:0] direct_addr;
    logic [WORD_W-1:0] alu_a;
    logic              alu_c;
    logic [WORD_W-1:0] pc_next;

    // Split the word on the read bus into opcode and direct address.
    always_comb begin
        rd_op       = opcode_t'(mem_rdata[WORD_W-1 -: OP_W]);
        direct_addr = {{OP_W{1'b0}}, mem_rdata[ADDR_W-1:0]};
    end

    acc_phase phase_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetched_op (rd_op),
        .phase_q    (phase_q)
    );

    acc_alu #(.W(WORD_W)) alu_i (
        .op         (op_q),
        .acc        (a_q),
        .operand    (mem_rdata),
        .carry      (c_q),
        .acc_next   (alu_a),
        .carry_next (alu_c)
    );

    acc_pcunit #(.W(WORD_W)) pcu_i (
        .op          (op_q),
        .pc          (pc_q),
        .vector_word (mem_rdata),
        .carry       (c_q),
        .zero        (z_q),
        .pc_next     (pc_next)
    );

    // Drive the memory port according to the current phase.
    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = (rd_op == OP_STT) ? t_q : a_q;
        unique case (phase_q)
            PH_DATA: begin
                mem_addr = (rd_op == OP_LDI || rd_op == OP_STT) ? a_q : direct_addr;
                mem_we   = (rd_op == OP_STA) || (rd_op == OP_STT);
            end
            PH_FETCH: mem_addr = pc_next;
            default:  mem_addr = pc_q;
        endcase
    end

    // Hold the opcode over the data cycle; commit state at the end of the fetch cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q  <= '0;
            t_q  <= '0;
            pc_q <= '0;
            c_q  <= 1'b0;
            z_q  <= 1'b1;
            op_q <= OP_HALT;
        end else begin
            if (phase_q == PH_DATA) begin
                op_q <= rd_op;
            end
            if (phase_q == PH_FETCH) begin
                a_q  <= alu_a;
                c_q  <= alu_c;
                z_q  <= (alu_a == '0);
                pc_q <= pc_next;
                if (op_q == OP_TAT) begin
                    t_q <= a_q;
                end
            end
        end
    end

    // Expose the architectural state.
    always_comb begin
        dbg_a  = a_q;
        dbg_pc = pc_q;
        dbg_c  = c_q;
        dbg_z  = z_q;
    end

endmodule

// File: rtl/acc_core_chk.sv
// Module: acc_core_chk
// Cycle-level properties of acc_core, attached with bind below.
// Assumes: the default 16-bit word.
module acc_core_chk
    import acc_cpu_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input phase_t      phase_q,
    input opcode_t     op_q,
    input opcode_t     rd_op,
    input logic        mem_we,
    input logic [15:0] mem_wdata,
    input logic [15:0] dbg_a,
    input logic [15:0] dbg_pc,
    input logic        dbg_c,
    input logic        dbg_z
);

    assert_we_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_pc_moves_in_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_FETCH) |=> $stable(dbg_pc));

    assert_bcc_falls_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_FETCH && op_q == OP_BCC && dbg_c) |=> (dbg_pc == $past(dbg_pc) + 16'd1));

    assert_sta_drives_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && rd_op == OP_STA) |-> (mem_wdata == dbg_a));

    assert_carry_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_FETCH || !writes_carry(op_q)) |=> $stable(dbg_c));

    assert_zero_tracks_a_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_z == (dbg_a == 16'd0));

    assert_halt_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HALT) |=> (phase_q == PH_HALT && $stable(dbg_pc) && $stable(dbg_a) && !mem_we));

endmodule

bind acc_core acc_core_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_q   (phase_q),
    .op_q      (op_q),
    .rd_op     (rd_op),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .dbg_a     (dbg_a),
    .dbg_pc    (dbg_pc),
    .dbg_c     (dbg_c),
    .dbg_z     (dbg_z)
);

// File: tb/acc_core_tb_top.sv
`timescale 1ns/1ps
// Bench for acc_core: a table of single-operation programs, then directed
// programs for timing, branches, the scratch register path, halt and reset.
module acc_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_rdata, mem_wdata;
    logic        mem_we;
    logic [15:0] dbg_a, dbg_pc;
    logic        dbg_c, dbg_z;

    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] mem [256];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    acc_core dut_i (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we),
        .dbg_a(dbg_a), .dbg_pc(dbg_pc), .dbg_c(dbg_c), .dbg_z(dbg_z)
    );

    // Synchronous memory model with a bench load port.
    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    // Opcode values from R1
    localparam logic [3:0] JMP = 0, BCC = 1, BNE = 2, LDC = 3, LDA = 4, STA = 5,
        XOR_ = 6, OR_ = 7, AND_ = 8, ADC = 9, SBC = 10, ROR = 11, TAT = 12,
        LDI = 13, STT = 14, HLT = 15;

    function automatic logic [15:0] ins(logic [3:0] op, logic [11:0] a);
        return {op, a};
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic poke(logic [7:0] a, logic [15:0] d);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic prep();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 256; i++) poke(8'(i), 16'h0000);
    endtask

    task automatic run(int cycles);
        rst_n = 1'b1;
        repeat (cycles) @(negedge clk);
    endtask

    // Vector: op, carry in, A, operand, expected A, expected C
    localparam int NV = 13;
    localparam logic [53:0] VEC [NV] = '{
        {XOR_, 1'b0, 16'hF0F0, 16'hFF00, 16'h0FF0, 1'b0},  // R8
        {OR_,  1'b1, 16'h1200, 16'h0034, 16'h1234, 1'b1},  // R8
        {AND_, 1'b0, 16'hF0F0, 16'h3C3C, 16'h3030, 1'b0},  // R8
        {ADC,  1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1},  // R9 carry-out
        {ADC,  1'b1, 16'h1000, 16'h0234, 16'h1234, 1'b0},  // R9 no carry-in
        {SBC,  1'b1, 16'h0000, 16'h0000, 16'hFFFF, 1'b1},  // R10 borrow
        {SBC,  1'b0, 16'h5000, 16'h1000, 16'h4000, 1'b0},  // R10
        {SBC,  1'b1, 16'h0005, 16'h0003, 16'h0001, 1'b0},  // R10
        {ROR,  1'b1, 16'h0002, 16'h0000, 16'h8001, 1'b0},  // R11
        {ROR,  1'b0, 16'h0003, 16'h0000, 16'h0001, 1'b1},  // R11
        {LDC,  1'b1, 16'h1111, 16'h0000, 16'h0000, 1'b0},  // R6
        {LDA,  1'b1, 16'h1111, 16'hABCD, 16'hABCD, 1'b1},  // R6
        {XOR_, 1'b1, 16'hAAAA, 16'h5555, 16'hFFFF, 1'b1}   // R12 carry held
    };

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R2 actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R14 reset state
        prep();
        chk("R14 A", dbg_a, 16'h0000);
        chk("R14 PC", dbg_pc, 16'h0000);
        chk("R14 C", 16'(dbg_c), 16'h0);
        chk("R14 Z", 16'(dbg_z), 16'h1);
        chk("R14 we", 16'(mem_we), 16'h0);

        // Table walk: set C, load A, apply op, store, halt (R1 encoding)
        for (int v = 0; v < NV; v++) begin
            logic [3:0]  op;
            logic        cin, ec;
            logic [15:0] av, dv, ea;
            {op, cin, av, dv, ea, ec} = VEC[v];
            prep();
            poke(8'h00, ins(LDC, 12'h040));
            poke(8'h01, ins(ROR, 12'h000));
            poke(8'h02, ins(LDA, 12'h041));
            poke(8'h03, ins(op,  12'h042));
            poke(8'h04, ins(STA, 12'h043));
            poke(8'h05, ins(HLT, 12'h000));
            poke(8'h40, {15'd0, cin});
            poke(8'h41, av);
            poke(8'h42, dv);
            run(40);
            chk($sformatf("R8-11 vec%0d A", v), dbg_a, ea);
            chk($sformatf("R12 vec%0d C", v), 16'(dbg_c), 16'(ec));
            chk($sformatf("R12 vec%0d Z", v), 16'(dbg_z), 16'(ea == 16'h0));
            chk($sformatf("R7 vec%0d stored", v), mem[8'h43], ea);
            chk($sformatf("R13 vec%0d halt pc", v), dbg_pc, 16'h0005);
        end

        // R2 two cycles per instruction
        prep();
        for (int i = 0; i < 8; i++) poke(8'(i), ins(LDA, 12'h040));
        poke(8'h40, 16'h0077);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2 pc after 3 edges", dbg_pc, 16'h0001);
        chk("R2 A after first", dbg_a, 16'h0077);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2 pc after 6 edges", dbg_pc, 16'h0002);
        @(posedge clk);
        @(negedge clk);
        chk("R2 pc after 7 edges", dbg_pc, 16'h0003);

        // R3 JMP indirect (R1 address field)
        prep();
        poke(8'h00, ins(JMP, 12'h040));
        poke(8'h40, 16'h0020);
        poke(8'h20, ins(HLT, 12'h000));
        run(20);
        chk("R3 jmp target", dbg_pc, 16'h0020);

        // R4 BCC taken with C=0
        prep();
        poke(8'h00, ins(BCC, 12'h040));
        poke(8'h40, 16'h0020);
        poke(8'h20, ins(HLT, 12'h000));
        run(20);
        chk("R4 bcc taken", dbg_pc, 16'h0020);

        // R4 BCC not taken with C=1
        prep();
        poke(8'h00, ins(LDC, 12'h041));
        poke(8'h01, ins(ROR, 12'h000));
        poke(8'h02, ins(BCC, 12'h040));
        poke(8'h03, ins(HLT, 12'h000));
        poke(8'h40, 16'h0020);
        poke(8'h41, 16'h0001);
        poke(8'h20, ins(HLT, 12'h000));
        run(30);
        chk("R4 bcc not taken", dbg_pc, 16'h0003);

        // R5 BNE taken with A nonzero
        prep();
        poke(8'h00, ins(LDA, 12'h041));
        poke(8'h01, ins(BNE, 12'h040));
        poke(8'h02, ins(HLT, 12'h000));
        poke(8'h40, 16'h0020);
        poke(8'h41, 16'h0001);
        poke(8'h20, ins(HLT, 12'h000));
        run(30);
        chk("R5 bne taken", dbg_pc, 16'h0020);

        // R5 BNE not taken with A zero
        prep();
        poke(8'h00, ins(LDA, 12'h042));
        poke(8'h01, ins(BNE, 12'h040));
        poke(8'h02, ins(HLT, 12'h000));
        poke(8'h40, 16'h0020);
        poke(8'h20, ins(HLT, 12'h000));
        run(30);
        chk("R5 bne not taken", dbg_pc, 16'h0002);

        // R7 TAT/STT and R6 LDI
        prep();
        poke(8'h00, ins(LDA, 12'h040));
        poke(8'h01, ins(TAT, 12'h000));
        poke(8'h02, ins(LDA, 12'h041));
        poke(8'h03, ins(STT, 12'h000));
        poke(8'h04, ins(LDI, 12'h000));
        poke(8'h05, ins(HLT, 12'h000));
        poke(8'h40, 16'h1234);
        poke(8'h41, 16'h0050);
        run(40);
        chk("R7 stt wrote T", mem[8'h50], 16'h1234);
        chk("R7 pointer untouched", mem[8'h41], 16'h0050);
        chk("R6 ldi loaded", dbg_a, 16'h1234);

        // R13 halt at address 0 freezes everything
        prep();
        poke(8'h00, ins(HLT, 12'h000));
        poke(8'h01, ins(LDA, 12'h040));
        poke(8'h40, 16'h5555);
        run(30);
        chk("R13 pc frozen", dbg_pc, 16'h0000);
        chk("R13 A frozen", dbg_a, 16'h0000);
        chk("R13 no write", mem[8'h00], ins(HLT, 12'h000));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule